// File: doc/BRIEF.md
# Multi-Semantics Floating-Point Min/Max Selector

This block takes two vectors of single-precision (32-bit) binary floating-point lanes and produces, lane by lane, either the minimum or the maximum of the pair. A 4-bit type control picks the language convention that governs NaN operands and pairs of signed zeros: IEEE minNum/maxNum, Java, C macro, C++ or Fortran. The top bit of that control requests absolute-value operation. Every lane also reports an invalid-operation flag.

Each lane classifies its two operands as NaN, signaling NaN, zero or negative. It then returns one of five things: the ordinary numeric min/max, operand A, operand B, a quieted copy of A, or a quieted copy of B. A single-lane control restricts the operation to lane 0. Results and flags are registered, so they appear one clock after the inputs are presented.

Top module: `fpmm_minmax`

## Requirements
- R1: A synchronous active-high reset clears the result vector and all invalid flags. Outside reset, the outputs show the result for the inputs sampled at the previous rising edge (latency of one clock).
- R2: For operands that are neither NaN nor both zero, the lane returns the numerically smaller operand when sel_max=0 and the larger when sel_max=1, using a sign-magnitude comparison, and raises no invalid flag. Lane i occupies bits [32*i+31:32*i].
- R3: Type values 1 to 4 have absolute-value forms at type+8 (9 to 12). In those forms both operands have their sign bit cleared before any classification or selection, so the result is never negative.
- R4: For types 1 to 4 and 9 to 12, the lane flag is set if either operand is a signaling NaN (exponent all ones, fraction nonzero, fraction bit 22 clear). Quieting a NaN sets bit 22 and keeps the sign and the other payload bits.
- R5: Java (type 1), with any NaN operand: a signaling A gives quieted A. Otherwise a signaling B gives quieted B. Otherwise the result is A if A is a NaN and B if not. The flag is clear when neither operand is signaling.
- R6: Fortran (type 4), with any NaN operand: the result is A when B is a NaN and B otherwise, with no quieting.
- R7: With any NaN operand, C macro (type 2) always returns B and C++ (type 3) always returns A. Both raise the invalid flag even for quiet NaNs.
- R8: Both operands zero, minimum: Java and Fortran return A if A is negative and B otherwise; C macro returns B; C++ returns A.
- R9: Both operands zero, maximum: Java and Fortran return B if A is negative and A otherwise; C macro returns B; C++ returns A.
- R10: IEEE (type 0) behaves as follows. A quiet NaN paired with a number yields the number with no flag. A signaling NaN yields the quieted signaling operand (A first) and sets the flag. Two quiet NaNs yield A. Among numbers, -0 ranks below +0.
- R11: IEEE magnitude (type 8) compares absolute values but returns the chosen operand with its original sign. Equal magnitudes are resolved as in R10. NaN handling matches R10.
- R12: When single_lane is 1, only lane 0 is computed; all other lanes output zero with a clear flag.
- R13: Reserved type values 5 to 7 behave as type 0, and 13 to 15 behave as type 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| vec_a | input | 32*LANES | Operand A lanes, lane 0 in the low bits |
| vec_b | input | 32*LANES | Operand B lanes |
| sel_max | input | 1 | 0 selects minimum, 1 selects maximum |
| kind | input | 4 | Semantics type; bit 3 requests absolute-value mode |
| single_lane | input | 1 | Restrict the operation to lane 0 |
| res_vec | output | 32*LANES | Registered result lanes |
| lane_invalid | output | LANES | Registered invalid-operation flag per lane |

## Verification
There is no state beyond the output register, so a wrong selection or classification shows up at the ports exactly one clock after the offending operands are applied. Nothing can hide it or delay it. The stimulus therefore places NaNs, signaling NaNs and signed zeros in different lanes in the same cycle, under every type and both directions. This way a mix-up between lanes, a swapped A/B preference or a missed quieting bit changes the very next compared result vector. Random runs add mixes of special and ordinary values, with single-lane mode turned on and off, so that stale upper lanes are also exposed.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  localparam int FP_W   = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = FP_W - 1 - EXP_W;
  localparam int QBIT   = FRAC_W - 1;

  typedef enum logic [2:0] {
    K_IEEE = 3'd0,
    K_JAVA = 3'd1,
    K_CMAC = 3'd2,
    K_CPP  = 3'd3,
    K_FORT = 3'd4
  } fpmm_kind_e;

  typedef struct packed {
    logic nan;
    logic snan;
    logic zero;
    logic neg;
  } fcls_t;

  function automatic logic [FP_W-1:0] quieten(input logic [FP_W-1:0] x);
    logic [FP_W-1:0] q;
    q = x;
    q[QBIT] = 1'b1;
    return q;
  endfunction
endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
  import fpmm_pkg::*;
(
  input  logic [FP_W-1:0] x,
  output fcls_t           cls
);
  logic exp_ones, frac_nz;
  always_comb begin
    exp_ones = &x[FP_W-2:FRAC_W];
    frac_nz  = |x[FRAC_W-1:0];
    cls.nan  = exp_ones && frac_nz;
    cls.snan = exp_ones && frac_nz && !x[QBIT];
    cls.zero = ~|x[FP_W-2:0];
    cls.neg  = x[FP_W-1];
  end
endmodule

// File: rtl/fpmm_order.sv
module fpmm_order
  import fpmm_pkg::*;
(
  input  logic [FP_W-1:0] a,
  input  logic [FP_W-1:0] b,
  output logic            key_lt,
  output logic            mag_lt,
  output logic            mag_eq
);
  logic [FP_W-1:0] key_a, key_b;
  always_comb begin
    key_a  = a[FP_W-1] ? ~a : {1'b1, a[FP_W-2:0]};
    key_b  = b[FP_W-1] ? ~b : {1'b1, b[FP_W-2:0]};
    key_lt = key_a < key_b;
    mag_lt = a[FP_W-2:0] < b[FP_W-2:0];
    mag_eq = a[FP_W-2:0] == b[FP_W-2:0];
  end
endmodule

// File: rtl/fpmm_lane.sv
module fpmm_lane
  import fpmm_pkg::*;
(
  input  logic [FP_W-1:0] a_in,
  input  logic [FP_W-1:0] b_in,
  input  logic            want_max,
  input  fpmm_kind_e      kind,
  input  logic            mag_mode,
  output logic [FP_W-1:0] res,
  output logic            inv
);
  logic            clear_sign;
  logic [FP_W-1:0] a, b;
  fcls_t           ca, cb;
  logic            key_lt, mag_lt, mag_eq;
  logic [FP_W-1:0] signed_pick, mag_pick;

  assign clear_sign = mag_mode && (kind != K_IEEE);
  assign a = clear_sign ? {1'b0, a_in[FP_W-2:0]} : a_in;
  assign b = clear_sign ? {1'b0, b_in[FP_W-2:0]} : b_in;

  fpmm_classify u_cls_a (.x(a), .cls(ca));
  fpmm_classify u_cls_b (.x(b), .cls(cb));
  fpmm_order    u_ord   (.a(a), .b(b), .key_lt(key_lt), .mag_lt(mag_lt), .mag_eq(mag_eq));

  always_comb begin
    signed_pick = (want_max ^ key_lt) ? a : b;
    if (mag_eq)      mag_pick = signed_pick;
    else             mag_pick = (want_max ^ mag_lt) ? a : b;
  end

  always_comb begin
    res = signed_pick;
    inv = 1'b0;
    if (kind == K_IEEE) begin
      if (ca.snan) begin
        res = quieten(a);
        inv = 1'b1;
      end else if (cb.snan) begin
        res = quieten(b);
        inv = 1'b1;
      end else if (ca.nan) begin
        res = a;
      end else if (cb.nan) begin
        res = a;
      end else begin
        res = mag_mode ? mag_pick : signed_pick;
      end
      if (!ca.snan && !cb.snan && !ca.nan && cb.nan) res = a;
      if (!ca.snan && !cb.snan && ca.nan && !cb.nan) res = b;
    end else if (ca.nan || cb.nan) begin
      inv = ca.snan || cb.snan;
      unique case (kind)
        K_JAVA: begin
          if (ca.snan)      res = quieten(a);
          else if (cb.snan) res = quieten(b);
          else              res = ca.nan ? a : b;
        end
        K_FORT:  res = cb.nan ? a : b;
        K_CMAC: begin res = b; inv = 1'b1; end
        default: begin res = a; inv = 1'b1; end
      endcase
    end else if (ca.zero && cb.zero) begin
      unique case (kind)
        K_JAVA, K_FORT: res = (ca.neg ^ want_max) ? a : b;
        K_CMAC:         res = b;
        default:        res = a;
      endcase
    end
  end
endmodule

// File: rtl/fpmm_minmax.sv
module fpmm_minmax
  import fpmm_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [FP_W*LANES-1:0] vec_a,
  input  logic [FP_W*LANES-1:0] vec_b,
  input  logic                  sel_max,
  input  logic [3:0]            kind,
  input  logic                  single_lane,
  output logic [FP_W*LANES-1:0] res_vec,
  output logic [LANES-1:0]      lane_invalid
);
  localparam int VEC_W = FP_W * LANES;

  fpmm_kind_e          base_kind;
  logic                mag_mode;
  logic [VEC_W-1:0]    lane_res;
  logic [LANES-1:0]    lane_inv;
  logic [LANES-1:0]    lane_on;

  always_comb begin
    mag_mode  = kind[3];
    base_kind = (kind[2:0] > 3'd4) ? K_IEEE : fpmm_kind_e'(kind[2:0]);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [FP_W-1:0] r;
    logic            f;
    assign lane_on[i] = (i == 0) || !single_lane;
    fpmm_lane u_lane (
      .a_in    (vec_a[FP_W*i +: FP_W]),
      .b_in    (vec_b[FP_W*i +: FP_W]),
      .want_max(sel_max),
      .kind    (base_kind),
      .mag_mode(mag_mode),
      .res     (r),
      .inv     (f)
    );
    assign lane_res[FP_W*i +: FP_W] = lane_on[i] ? r : '0;
    assign lane_inv[i]              = lane_on[i] && f;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vec      <= '0;
      lane_invalid <= '0;
    end else begin
      res_vec      <= lane_res;
      lane_invalid <= lane_inv;
    end
  end
endmodule

// File: rtl/fpmm_minmax_chk.sv
module fpmm_minmax_chk #(
  parameter int LANES = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [32*LANES-1:0] vec_a,
  input logic [32*LANES-1:0] vec_b,
  input logic                sel_max,
  input logic [3:0]          kind,
  input logic                single_lane,
  input logic [32*LANES-1:0] res_vec,
  input logic [LANES-1:0]    lane_invalid
);
  logic a0_nan, b0_nan, a0_sig, b0_sig;
  assign a0_nan = (&vec_a[30:23]) && (|vec_a[22:0]);
  assign b0_nan = (&vec_b[30:23]) && (|vec_b[22:0]);
  assign a0_sig = a0_nan && !vec_a[22];
  assign b0_sig = b0_nan && !vec_b[22];

  assert_rst_clear_R1: assert property (@(posedge clk)
    rst |=> (res_vec == '0) && (lane_invalid == '0));

  assert_snan_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (kind[2:0] >= 3'd1 && kind[2:0] <= 3'd4 && (a0_sig || b0_sig)) |=> lane_invalid[0]);

  assert_java_quiet_noflag_R5: assert property (@(posedge clk) disable iff (rst)
    (kind == 4'd1 && !a0_sig && !b0_sig) |=> !lane_invalid[0]);

  assert_cmacro_nan_R7: assert property (@(posedge clk) disable iff (rst)
    (kind == 4'd2 && (a0_nan || b0_nan)) |=> (res_vec[31:0] == $past(vec_b[31:0])) && lane_invalid[0]);

  assert_cpp_nan_R7: assert property (@(posedge clk) disable iff (rst)
    (kind == 4'd3 && (a0_nan || b0_nan)) |=> (res_vec[31:0] == $past(vec_a[31:0])) && lane_invalid[0]);

  assert_java_zero_min_R8: assert property (@(posedge clk) disable iff (rst)
    (kind == 4'd1 && !sel_max && vec_a[31:0] == 32'h8000_0000 && vec_b[31:0] == 32'h0)
    |=> res_vec[31:0] == 32'h8000_0000);

  assert_single_upper_R12: assert property (@(posedge clk) disable iff (rst)
    single_lane |=> (res_vec[32*LANES-1:32] == '0) && (lane_invalid[LANES-1:1] == '0));
endmodule

bind fpmm_minmax fpmm_minmax_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .vec_a(vec_a), .vec_b(vec_b), .sel_max(sel_max),
  .kind(kind), .single_lane(single_lane), .res_vec(res_vec), .lane_invalid(lane_invalid)
);

// File: tb/fpmm_minmax_test.sv
module fpmm_minmax_test;
  localparam int LANES = 4;
  localparam int VW = 32 * LANES;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [VW-1:0] vec_a = '0, vec_b = '0;
  logic sel_max = 1'b0, single_lane = 1'b0;
  logic [3:0] kind = 4'd0;
  logic [VW-1:0] res_vec;
  logic [LANES-1:0] lane_invalid;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fpmm_minmax #(.LANES(LANES)) uut (
    .clk(clk), .rst(rst), .vec_a(vec_a), .vec_b(vec_b), .sel_max(sel_max),
    .kind(kind), .single_lane(single_lane), .res_vec(res_vec), .lane_invalid(lane_invalid)
  );

  // Behavioural reference
  function automatic bit is_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction
  function automatic bit is_sig(input logic [31:0] x);
    return is_nan(x) && (x[22] == 1'b0);
  endfunction
  function automatic logic [31:0] qn(input logic [31:0] x);
    return x | 32'h0040_0000;
  endfunction
  function automatic longint num(input logic [31:0] x);
    longint m;
    m = longint'(x[30:0]);
    return x[31] ? -m : m;
  endfunction
  function automatic logic [31:0] pick(input logic [31:0] a, b, input bit mx);
    longint va, vb;
    va = num(a); vb = num(b);
    if (va < vb) return mx ? b : a;
    if (vb < va) return mx ? a : b;
    if (mx) return a[31] ? b : a;
    return a[31] ? a : b;
  endfunction

  task automatic ref_lane(input logic [31:0] ai, bi, input bit mx, input logic [3:0] k,
                          output logic [31:0] r, output bit f);
    int t;
    bit absm;
    logic [31:0] a, b;
    absm = k[3];
    t = int'(k[2:0]);
    if (t > 4) t = 0;
    a = ai; b = bi;
    if (absm && t != 0) begin a[31] = 1'b0; b[31] = 1'b0; end
    f = 1'b0;
    if (t == 0) begin
      if (is_sig(a)) begin r = qn(a); f = 1; end
      else if (is_sig(b)) begin r = qn(b); f = 1; end
      else if (is_nan(a) && is_nan(b)) r = a;
      else if (is_nan(a)) r = b;
      else if (is_nan(b)) r = a;
      else if (absm && a[30:0] != b[30:0]) r = ((a[30:0] < b[30:0]) ^ mx) ? a : b;
      else r = pick(a, b, mx);
    end else if (is_nan(a) || is_nan(b)) begin
      f = is_sig(a) || is_sig(b);
      if (t == 1) r = is_sig(a) ? qn(a) : is_sig(b) ? qn(b) : is_nan(a) ? a : b;
      else if (t == 4) r = is_nan(b) ? a : b;
      else if (t == 2) begin r = b; f = 1; end
      else begin r = a; f = 1; end
    end else if (a[30:0] == 0 && b[30:0] == 0) begin
      if (t == 2) r = b;
      else if (t == 3) r = a;
      else if (!mx) r = a[31] ? a : b;
      else r = a[31] ? b : a;
    end else r = pick(a, b, mx);
  endtask

  task automatic step(input logic [VW-1:0] a, b, input bit mx, input logic [3:0] k,
                      input bit sgl, input string req);
    logic [VW-1:0] er;
    logic [LANES-1:0] ef;
    logic [31:0] r;
    bit f;
    er = '0; ef = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i == 0 || !sgl) begin
        ref_lane(a[32*i +: 32], b[32*i +: 32], mx, k, r, f);
        er[32*i +: 32] = r;
        ef[i] = f;
      end
    end
    @(negedge clk);
    vec_a = a; vec_b = b; sel_max = mx; kind = k; single_lane = sgl;
    @(negedge clk);
    checks++;
    if (res_vec !== er || lane_invalid !== ef) begin
      failures++;
      $display("FAIL %s kind=%0d max=%0d act=%h/%b exp=%h/%b", req, k, mx,
               res_vec, lane_invalid, er, ef);
    end
  endtask

  function automatic logic [31:0] rnd_val();
    int s;
    s = $urandom_range(0, 9);
    case (s)
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return {$urandom_range(0,1) == 1, 8'hFF, 1'b1, 22'($urandom)};
      3: return {$urandom_range(0,1) == 1, 8'hFF, 1'b0, 21'($urandom), 1'b1};
      4: return {$urandom_range(0,1) == 1, 8'h7F, 23'h0};
      default: return $urandom;
    endcase
  endfunction

  localparam logic [31:0] P1 = 32'h3F80_0000, P2 = 32'h4000_0000, N3 = 32'hC040_0000;
  localparam logic [31:0] N1 = 32'hBF80_0000, QN = 32'h7FC0_0001, SN = 32'h7F80_0005;
  localparam logic [31:0] NSN = 32'hFF80_0005, PZ = 32'h0, NZ = 32'h8000_0000;

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (res_vec !== '0 || lane_invalid !== '0) begin
      failures++;
      $display("FAIL R1 reset act=%h/%b exp=0/0", res_vec, lane_invalid);
    end
    rst = 1'b0;
    // R2 ordinary values
    for (int k = 1; k <= 4; k++) begin
      step({P1, N3, P2, N1}, {P2, N1, N3, P1}, 1'b0, 4'(k), 1'b0, "R2");
      step({P1, N3, P2, N1}, {P2, N1, N3, P1}, 1'b1, 4'(k), 1'b0, "R2");
    end
    // R3 absolute-value forms
    for (int k = 9; k <= 12; k++) begin
      step({N3, N1, NZ, NSN}, {P2, P1, PZ, P1}, 1'b0, 4'(k), 1'b0, "R3");
      step({N3, N1, NZ, NSN}, {P2, P1, PZ, P1}, 1'b1, 4'(k), 1'b0, "R3");
    end
    // R4/R5/R6/R7 NaN handling per type
    for (int k = 1; k <= 4; k++) begin
      step({SN, QN, P1, SN}, {QN, P1, QN, SN | 32'h1}, 1'b0, 4'(k), 1'b0, "R4_R5_R6_R7");
      step({P1, QN, QN, N1}, {NSN, QN, N3, QN}, 1'b1, 4'(k), 1'b0, "R4_R5_R6_R7");
    end
    step({QN, P1, SN, NZ}, {P1, QN, SN, QN}, 1'b0, 4'd1, 1'b0, "R5");
    step({QN, P1, SN, NZ}, {P1, QN, SN, QN}, 1'b0, 4'd4, 1'b0, "R6");
    step({QN, P1, PZ, NZ}, {P1, QN, QN, QN}, 1'b1, 4'd2, 1'b0, "R7");
    step({QN, P1, PZ, NZ}, {P1, QN, QN, QN}, 1'b1, 4'd3, 1'b0, "R7");
    // R8/R9 signed zeros
    for (int k = 1; k <= 4; k++) begin
      step({NZ, PZ, NZ, PZ}, {PZ, NZ, NZ, PZ}, 1'b0, 4'(k), 1'b0, "R8");
      step({NZ, PZ, NZ, PZ}, {PZ, NZ, NZ, PZ}, 1'b1, 4'(k), 1'b0, "R9");
    end
    // R10/R11 IEEE and magnitude
    step({QN, P1, SN, NZ}, {P1, QN, P2, PZ}, 1'b0, 4'd0, 1'b0, "R10");
    step({QN, P1, NSN, NZ}, {QN, SN, P2, PZ}, 1'b1, 4'd0, 1'b0, "R10");
    step({N3, P1, N1, NZ}, {P2, N1, P2, PZ}, 1'b0, 4'd8, 1'b0, "R11");
    step({N3, P1, N1, NZ}, {P2, N1, P2, PZ}, 1'b1, 4'd8, 1'b0, "R11");
    // R12 single lane
    step({SN, P1, N1, P2}, {QN, P2, N3, NZ}, 1'b0, 4'd2, 1'b1, "R12");
    step({SN, P1, N1, P2}, {QN, P2, N3, NZ}, 1'b1, 4'd0, 1'b1, "R12");
    // R13 reserved types
    for (int k = 5; k <= 7; k++)
      step({QN, NZ, SN, N3}, {P1, PZ, P1, P2}, 1'b0, 4'(k), 1'b0, "R13");
    for (int k = 13; k <= 15; k++)
      step({N3, NZ, SN, N3}, {P2, PZ, P1, P1}, 1'b1, 4'(k), 1'b0, "R13");
    // random mixes
    for (int n = 0; n < 400; n++) begin
      logic [VW-1:0] ra, rb;
      for (int i = 0; i < LANES; i++) begin
        ra[32*i +: 32] = rnd_val();
        rb[32*i +: 32] = rnd_val();
      end
      step(ra, rb, 1'($urandom), 4'($urandom), ($urandom_range(0, 5) == 0), "R2_R13_random");
    end
    // R1 reset again mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    checks++;
    if (res_vec !== '0 || lane_invalid !== '0) begin
      failures++;
      $display("FAIL R1 reset act=%h/%b exp=0/0", res_vec, lane_invalid);
    end
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule